// File: doc/BRIEF.md
# Interleaved Four-Bank Block Refill Controller

This block fills one cache line from a main memory built as several word-interleaved banks behind a bus that is one word wide. A refill request carries a block address. The controller presents that address once. Every bank starts its access in the same cycle. When the shared access delay has passed, the controller moves the words of the block onto the bus, one word per cycle. The access delay is paid once per block, and only the word transfers are serialised. With the default settings a refill takes 11 cycles. A single bank would need 32 cycles for the same block, and a memory four words wide would need 8.

Each bank is a small register array. It holds one word of every block and has a fixed access delay. At reset every location is loaded with a value computed from its word address, so a refill always returns known data. A requester waits for `ready_o`, raises `req_i` together with the block address, and collects the four words on `word_o` while `word_vld_o` is high. `word_idx_o` tells which word of the block is on the bus. `done_o` marks the final word. The next request may follow in the cycle after `done_o`.

Top module: `ilv_refill_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `ready_o` is 1, `word_vld_o` is 0, `done_o` is 0 and `word_o` is 0.
- R2: Word address W is the block address times 4 plus the word index. Its two low bits select the bank and the remaining bits select the row within that bank. The word stored at W is 32'h5A17C3E0 XOR (W × 32'h9E3779B9), taken modulo 2^32.
- R3: Call the cycle in which a request is accepted (`req_i` and `ready_o` both 1 at the clock edge) cycle 1. Word 0 is on the bus in cycle 8, and the last word is on the bus in cycle 11 (1 + 6 + 4).
- R4: The words come back in bank order 0, 1, 2, 3, one per consecutive cycle. `word_vld_o` is high for exactly those four cycles, and `word_idx_o` carries the index of the word on the bus.
- R5: `done_o` is high for exactly one cycle, in the same cycle as word 3.
- R6: `ready_o` is 0 from the cycle after acceptance through the `done_o` cycle. A request made while `ready_o` is 0 is ignored: the address it carries is not used, and it does not start a refill.
- R7: A request made in the cycle right after `done_o` is accepted at once, with the same timing as in R3.
- R8: The lowest block address (0) and the highest (63) return the correct words for their rows.
- R9: `word_o` is 0 in every cycle in which `word_vld_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Refill request |
| blk_addr_i | input | 6 | Block address, sampled when the request is accepted |
| ready_o | output | 1 | Controller idle; a request will be accepted |
| word_vld_o | output | 1 | A word of the block is on the bus |
| word_idx_o | output | 2 | Index (bank) of the word on the bus |
| word_o | output | 32 | Bus data word |
| done_o | output | 1 | Final word of the refill is on the bus |

## Verification
The assertions assume three things. Reset is applied before the first request. `req_i` is never unknown after reset. The block address only has to be valid in the cycle that a request is accepted, because the banks capture it there and the controller ignores it afterwards. The stimulus meets these conditions: it changes every input on the falling edge, it keeps addresses inside the six-bit range, and it holds a request with a different address across one whole refill to show that such a request is discarded.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_ACCESS = 2'd1,
      ST_XFER   = 2'd2
   } ilv_state_e;

endpackage

// File: rtl/ilv_bank.sv
module ilv_bank #(
   parameter int          WORD_W    = 32,
   parameter int          ROW_W     = 6,
   parameter int          NUM_BANKS = 4,
   parameter int          BANK_ID   = 0,
   parameter int          ACC_CYC   = 6,
   parameter logic [31:0] FILL_SEED = 32'h5A17_C3E0,
   parameter logic [31:0] FILL_MULT = 32'h9E37_79B9
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              start_i,
   input  logic [ROW_W-1:0]  row_i,
   output logic [WORD_W-1:0] data_o
);

   localparam int DEPTH = 1 << ROW_W;
   localparam int CNT_W = $clog2(ACC_CYC + 1);
   localparam logic [CNT_W-1:0] ACC_LD = CNT_W'(ACC_CYC);

   initial begin
      assert (ACC_CYC >= 1) else $error("ilv_bank: ACC_CYC must be at least 1");
      assert (WORD_W <= 32) else $error("ilv_bank: WORD_W must not exceed 32");
      assert (BANK_ID < NUM_BANKS) else $error("ilv_bank: BANK_ID out of range");
   end

   function automatic logic [WORD_W-1:0] fill_word(input int row);
      logic [31:0] waddr;
      logic [31:0] val;
      waddr = 32'(row * NUM_BANKS + BANK_ID);
      val   = FILL_SEED ^ (waddr * FILL_MULT);
      return val[WORD_W-1:0];
   endfunction

   logic [WORD_W-1:0] mem_q [DEPTH];
   logic [CNT_W-1:0]  cnt_q;
   logic [ROW_W-1:0]  row_q;
   logic [WORD_W-1:0] data_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         for (int r = 0; r < DEPTH; r++) begin
            mem_q[r] <= fill_word(r);
         end
         cnt_q  <= '0;
         row_q  <= '0;
         data_q <= '0;
      end else begin
         if (start_i) begin
            cnt_q <= ACC_LD;
            row_q <= row_i;
         end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CNT_W'(1)) begin
               data_q <= mem_q[row_q];
            end
         end
      end
   end

   assign data_o = data_q;

   AST_BANK_DATA_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_q == '0) |=> $stable(data_q)); // R3

   AST_BANK_START_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_i |-> (cnt_q == '0)); // R6

endmodule

// File: rtl/ilv_seq.sv
module ilv_seq
   import ilv_pkg::*;
#(
   parameter int NUM_BANKS = 4,
   parameter int ACC_CYC   = 6,
   localparam int IDX_W    = $clog2(NUM_BANKS)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             req_i,
   output logic             ready_o,
   output logic             start_o,
   output logic             xfer_o,
   output logic [IDX_W-1:0] idx_o,
   output logic             done_o
);

   localparam int CNT_W = $clog2(ACC_CYC + 1);
   localparam logic [CNT_W-1:0] CNT_LD   = CNT_W'(ACC_CYC - 1);
   localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NUM_BANKS - 1);
   localparam int LAT_W = $clog2(ACC_CYC + NUM_BANKS + 2);
   localparam logic [LAT_W-1:0] LAT_MAX = '1;

   ilv_state_e       state_q;
   logic [CNT_W-1:0] cnt_q;
   logic [IDX_W-1:0] idx_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         idx_q   <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (req_i) begin
                  state_q <= ST_ACCESS;
                  cnt_q   <= CNT_LD;
               end
            end
            ST_ACCESS: begin
               if (cnt_q == '0) begin
                  state_q <= ST_XFER;
                  idx_q   <= '0;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            ST_XFER: begin
               if (idx_q == IDX_LAST) begin
                  state_q <= ST_IDLE;
                  idx_q   <= '0;
               end else begin
                  idx_q <= idx_q + 1'b1;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign ready_o = (state_q == ST_IDLE);
   assign start_o = ready_o && req_i;
   assign xfer_o  = (state_q == ST_XFER);
   assign idx_o   = idx_q;
   assign done_o  = xfer_o && (idx_q == IDX_LAST);

   // Cycles since acceptance, used to check the access window without deep $past
   logic [LAT_W-1:0] lat_q;
   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         lat_q <= '0;
      end else if (start_o) begin
         lat_q <= '0;
      end else if (lat_q != LAT_MAX) begin
         lat_q <= lat_q + 1'b1;
      end
   end

   AST_FIRST_WORD_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(xfer_o) |-> (lat_q == LAT_W'(ACC_CYC))); // R3

   AST_FIRST_WORD_INDEX: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(xfer_o) |-> (idx_o == '0)); // R4

   AST_INDEX_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (xfer_o && !done_o) |=> (xfer_o && idx_o == $past(idx_o) + 1'b1)); // R4

   AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !done_o); // R5

   AST_READY_AFTER_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> ready_o); // R7

   AST_BUSY_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!ready_o && !done_o) |=> !ready_o); // R6

endmodule

// File: rtl/ilv_word_sel.sv
module ilv_word_sel #(
   parameter int WORD_W        = 32,
   parameter int NUM_BANKS     = 4,
   parameter bit ZERO_IDLE_BUS = 1'b1,
   localparam int IDX_W        = $clog2(NUM_BANKS)
) (
   input  logic [NUM_BANKS-1:0][WORD_W-1:0] words_i,
   input  logic [IDX_W-1:0]                 sel_i,
   input  logic                             vld_i,
   output logic [WORD_W-1:0]                word_o
);

   logic [WORD_W-1:0] picked;
   assign picked = words_i[sel_i];

   generate
      if (ZERO_IDLE_BUS) begin : g_gated
         assign word_o = vld_i ? picked : '0;
      end else begin : g_raw
         logic unused_vld;
         assign unused_vld = vld_i;
         assign word_o     = picked;
      end
   endgenerate

endmodule

// File: rtl/ilv_refill_ctrl.sv
module ilv_refill_ctrl #(
   parameter int          WORD_W        = 32,
   parameter int          NUM_BANKS     = 4,
   parameter int          BLK_W         = 6,
   parameter int          ACC_CYC       = 6,
   parameter logic [31:0] FILL_SEED     = 32'h5A17_C3E0,
   parameter logic [31:0] FILL_MULT     = 32'h9E37_79B9,
   parameter bit          ZERO_IDLE_BUS = 1'b1,
   localparam int         IDX_W         = $clog2(NUM_BANKS)
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              req_i,
   input  logic [BLK_W-1:0]  blk_addr_i,
   output logic              ready_o,
   output logic              word_vld_o,
   output logic [IDX_W-1:0]  word_idx_o,
   output logic [WORD_W-1:0] word_o,
   output logic              done_o
);

   initial begin
      assert (NUM_BANKS >= 2 && (1 << IDX_W) == NUM_BANKS)
         else $error("ilv_refill_ctrl: NUM_BANKS must be a power of two >= 2");
      assert (ACC_CYC >= 1) else $error("ilv_refill_ctrl: ACC_CYC must be at least 1");
      assert (BLK_W >= 1 && BLK_W <= 10) else $error("ilv_refill_ctrl: BLK_W out of range");
   end

   logic                             start;
   logic                             xfer;
   logic [IDX_W-1:0]                 idx;
   logic [NUM_BANKS-1:0][WORD_W-1:0] bank_words;

   ilv_seq #(
      .NUM_BANKS (NUM_BANKS),
      .ACC_CYC   (ACC_CYC)
   ) i_seq (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .req_i   (req_i),
      .ready_o (ready_o),
      .start_o (start),
      .xfer_o  (xfer),
      .idx_o   (idx),
      .done_o  (done_o)
   );

   generate
      for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
         ilv_bank #(
            .WORD_W    (WORD_W),
            .ROW_W     (BLK_W),
            .NUM_BANKS (NUM_BANKS),
            .BANK_ID   (b),
            .ACC_CYC   (ACC_CYC),
            .FILL_SEED (FILL_SEED),
            .FILL_MULT (FILL_MULT)
         ) i_bank (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .start_i (start),
            .row_i   (blk_addr_i),
            .data_o  (bank_words[b])
         );
      end
   endgenerate

   ilv_word_sel #(
      .WORD_W        (WORD_W),
      .NUM_BANKS     (NUM_BANKS),
      .ZERO_IDLE_BUS (ZERO_IDLE_BUS)
   ) i_sel (
      .words_i (bank_words),
      .sel_i   (idx),
      .vld_i   (xfer),
      .word_o  (word_o)
   );

   assign word_vld_o = xfer;
   assign word_idx_o = idx;

   AST_VLD_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      word_vld_o |-> !ready_o); // R6

   AST_DONE_WITH_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> word_vld_o); // R5

endmodule

// File: tb/test_ilv_refill_ctrl.sv
module test_ilv_refill_ctrl;

   localparam int          WORD_W = 32;
   localparam int          BLK_W  = 6;
   localparam int          ACC    = 6;
   localparam int          NB     = 4;
   localparam logic [31:0] SEED   = 32'h5A17_C3E0;
   localparam logic [31:0] MULT   = 32'h9E37_79B9;
   localparam int          FIRST  = ACC;          // edges after acceptance until word 0
   localparam int          LASTK  = ACC + NB;     // edge after which controller is idle again

   // Vector table: {gap_before[7], hold_req[6], block[5:0]}
   localparam int NVEC = 6;
   localparam logic [7:0] VEC [NVEC] = '{
      8'b1_0_000000,   // block 0 (R8)
      8'b1_0_111111,   // block 63 (R8)
      8'b0_0_010101,   // back-to-back (R7)
      8'b1_0_101010,
      8'b1_1_001100,   // request held while busy (R6)
      8'b0_0_110011    // back-to-back (R7)
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req = 1'b0;
   logic [BLK_W-1:0]  blk = '0;
   logic              ready;
   logic              vld;
   logic [1:0]        idx;
   logic [WORD_W-1:0] word;
   logic              done;

   int n_tests = 0;
   int n_fail  = 0;

   always #4 clk = ~clk;

   ilv_refill_ctrl #(
      .WORD_W    (WORD_W),
      .NUM_BANKS (NB),
      .BLK_W     (BLK_W),
      .ACC_CYC   (ACC),
      .FILL_SEED (SEED),
      .FILL_MULT (MULT)
   ) i_ilv_refill_ctrl (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .req_i      (req),
      .blk_addr_i (blk),
      .ready_o    (ready),
      .word_vld_o (vld),
      .word_idx_o (idx),
      .word_o     (word),
      .done_o     (done)
   );

   function automatic logic [31:0] exp_word(input int b, input int i);
      logic [31:0] wa;
      wa = 32'(b * 4 + i);
      return SEED ^ (wa * MULT);
   endfunction

   task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h at %0t", rq, act, exp, $time);
      end
   endtask

   // Issue a refill from the current negedge; ends at the negedge where ready is back.
   task automatic refill(input int b, input bit hold);
      check("R7 ready before request", 32'(ready), 32'd1);
      req = 1'b1;
      blk = BLK_W'(b);
      @(posedge clk);
      for (int k = 0; k <= LASTK; k++) begin
         @(negedge clk);
         if (k == 0) begin
            if (hold) blk = ~BLK_W'(b);
            else      req = 1'b0;
         end
         if (k == LASTK) req = 1'b0;
         begin
            bit ev;
            ev = (k >= FIRST) && (k < FIRST + NB);
            check("R4 word valid", 32'(vld), 32'(ev));
            check("R5 done", 32'(done), 32'(k == LASTK - 1));
            check("R6 ready", 32'(ready), 32'(k == LASTK));
            if (ev) begin
               check("R4 word index", 32'(idx), 32'(k - FIRST));
               check("R2 word data", word, exp_word(b, k - FIRST));
               if (k == FIRST) check("R3 first word cycle", 32'(k + 2), 32'd8);
               if (k == LASTK - 1) check("R3 last word cycle", 32'(k + 2), 32'(1 + ACC + NB));
            end else begin
               check("R9 idle bus", word, 32'd0);
            end
         end
         if (k < LASTK) @(posedge clk);
      end
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin : main
      // R1: reset state
      repeat (3) @(negedge clk);
      check("R1 ready in reset", 32'(ready), 32'd1);
      check("R1 valid in reset", 32'(vld), 32'd0);
      check("R1 done in reset", 32'(done), 32'd0);
      check("R1 word in reset", word, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 ready after reset", 32'(ready), 32'd1);
      check("R1 valid after reset", 32'(vld), 32'd0);

      // Vector walk
      for (int v = 0; v < NVEC; v++) begin
         if (VEC[v][7]) @(negedge clk);
         refill(int'(VEC[v][5:0]), VEC[v][6]);
         if (VEC[v][6]) begin
            // R6: held request during busy did not start another refill
            for (int q = 0; q < 12; q++) begin
               @(negedge clk);
               check("R6 no refill from ignored request", 32'(vld), 32'd0);
               check("R6 ready stays idle", 32'(ready), 32'd1);
            end
         end
      end

      // Directed: R8 boundary blocks again, R7 back-to-back pair
      @(negedge clk);
      refill(63, 1'b0);
      refill(0, 1'b0);

      // Directed: quiet bus with no request (R9)
      for (int q = 0; q < 5; q++) begin
         @(negedge clk);
         check("R9 quiet bus", word, 32'd0);
      end

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule